// File: doc/BRIEF.md
# Programmable Logic Output Macrocell

This block is one output cell of a sum-of-products programmable logic device. It takes the OR-sum built for its pin, the pin's own output-enable product term, and the two product terms shared by every cell: a synchronous preset and an asynchronous clear. From these it produces the value and enable for a three-state pad, and a feedback pair (true and complement) that returns to the AND array.

A two-bit configuration word picks one of four modes. A cell can be registered or combinational, and each of these can drive the pin active-high or active-low. The register is clocked from the pin that also serves as dedicated input 0. The register is modelled as a two-state machine with the states `ST_LOW` and `ST_HIGH`. Its transitions are:

- `CLEAR`: asynchronous, into `ST_LOW`.
- `PRESET`: on the clock edge, into `ST_HIGH`.
- `LOAD`: on the clock edge, into `ST_HIGH` if the OR-sum is 1, otherwise into `ST_LOW`.

The three-state buffer itself sits in the pad ring. The cell only supplies its data and enable signals and reads back the pad level.

Top module: `pld_macrocell`

## Requirements
- R1: Configuration bit 0 set to 1 selects combinational mode and 0 selects registered mode. Configuration bit 1 set to 1 selects active-high and 0 selects active-low.
- R2: When neither preset nor clear is active, each rising clock edge loads the OR-sum into the register (transition LOAD).
- R3: An active synchronous preset term sets the register to 1 on the next rising edge, whatever the OR-sum is (transition PRESET).
- R4: An active asynchronous clear term forces the register to 0 at once, without a clock edge. Clear wins over preset (transition CLEAR).
- R5: In registered modes the pad value is the register output when active-high and its inverse when active-low.
- R6: In combinational modes the pad value follows the OR-sum in the same cycle, inverted when active-low.
- R7: The pad enable equals the cell's output-enable product term in every mode.
- R8: In registered modes the true feedback equals the register output. The complement feedback is always the inverse of the true feedback.
- R9: In combinational modes the true feedback is the level read back from the pad, whatever the output enable is, so a disabled pin acts as an input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, taken from the shared clock/input-0 pin |
| aclr_term | input | 1 | Global asynchronous clear product term, active high |
| spre_term | input | 1 | Global synchronous preset product term, active high |
| or_sum | input | 1 | OR of this cell's product terms |
| oe_term | input | 1 | This cell's output-enable product term |
| cfg | input | 2 | Mode: bit 0 selects combinational, bit 1 selects active-high |
| pad_in | input | 1 | Level read back from the pad |
| pad_out | output | 1 | Data to the pad driver |
| pad_oe | output | 1 | Enable for the pad driver |
| fb_true | output | 1 | True feedback line to the array |
| fb_comp | output | 1 | Complement feedback line to the array |

## Verification
The bench asserts preset and clear together to check priority. A design that ranks preset above clear would leave the register at 1. It raises clear between clock edges and checks that the register drops before the next edge. A design with a synchronous clear would hold its old value until that edge. In combinational mode the bench drives the pad readback with a value that differs from the OR-sum while the output is disabled. A feedback selector tied to the logic path instead of the pad would return the wrong value. It runs all four modes with both OR-sum values. A design with a swapped configuration encoding, or with inversion placed before the register, would show the wrong pad level.

// File: rtl/pld_mc_pkg.sv
package pld_mc_pkg;
    localparam int CFG_W       = 2;
    localparam int CFG_COMB    = 0;
    localparam int CFG_ACTHIGH = 1;

    typedef enum logic {
        ST_LOW  = 1'b0,
        ST_HIGH = 1'b1
    } reg_state_t;

    typedef struct packed {
        logic comb;
        logic act_high;
    } mode_t;

    function automatic mode_t decode_cfg(input logic [CFG_W-1:0] c);
        mode_t m;
        m.comb     = c[CFG_COMB];
        m.act_high = c[CFG_ACTHIGH];
        return m;
    endfunction
endpackage

// File: rtl/pld_mc_regstage.sv
module pld_mc_regstage
    import pld_mc_pkg::*;
(
    input  logic clk,
    input  logic aclr,
    input  logic spre,
    input  logic d,
    output logic q
);
    reg_state_t state_q, state_d;

    // next-state selection: preset beats data
    always_comb begin
        unique case ({spre, d})
            2'b10, 2'b11: state_d = ST_HIGH;
            2'b01:        state_d = ST_HIGH;
            2'b00:        state_d = ST_LOW;
            default:      state_d = ST_LOW;
        endcase
    end

    // state register with asynchronous clear
    always_ff @(posedge clk or posedge aclr) begin
        if (aclr) state_q <= ST_LOW;
        else      state_q <= state_d;
    end

    // output decode
    always_comb begin
        unique case (state_q)
            ST_HIGH: q = 1'b1;
            ST_LOW:  q = 1'b0;
            default: q = 1'b0;
        endcase
    end
endmodule

// File: rtl/pld_mc_outmux.sv
module pld_mc_outmux
    import pld_mc_pkg::*;
(
    input  mode_t mode,
    input  logic  q,
    input  logic  sum,
    input  logic  oe,
    output logic  data,
    output logic  en
);
    logic raw;

    always_comb begin
        raw  = mode.comb ? sum : q;
        data = mode.act_high ? raw : ~raw;
        en   = oe;
    end
endmodule

// File: rtl/pld_mc_fbsel.sv
module pld_mc_fbsel
    import pld_mc_pkg::*;
(
    input  mode_t mode,
    input  logic  q,
    input  logic  pin,
    output logic  fb_t,
    output logic  fb_c
);
    always_comb begin
        fb_t = mode.comb ? pin : q;
        fb_c = ~fb_t;
    end
endmodule

// File: rtl/pld_macrocell.sv
module pld_macrocell
    import pld_mc_pkg::*;
(
    input  logic             clk,
    input  logic             aclr_term,
    input  logic             spre_term,
    input  logic             or_sum,
    input  logic             oe_term,
    input  logic [CFG_W-1:0] cfg,
    input  logic             pad_in,
    output logic             pad_out,
    output logic             pad_oe,
    output logic             fb_true,
    output logic             fb_comp
);
    mode_t mode;
    logic  reg_q;

    assign mode = decode_cfg(cfg);

    pld_mc_regstage u_reg (
        .clk  (clk),
        .aclr (aclr_term),
        .spre (spre_term),
        .d    (or_sum),
        .q    (reg_q)
    );

    pld_mc_outmux u_out (
        .mode (mode),
        .q    (reg_q),
        .sum  (or_sum),
        .oe   (oe_term),
        .data (pad_out),
        .en   (pad_oe)
    );

    pld_mc_fbsel u_fb (
        .mode (mode),
        .q    (reg_q),
        .pin  (pad_in),
        .fb_t (fb_true),
        .fb_c (fb_comp)
    );
endmodule

// File: rtl/pld_mc_checker.sv
module pld_mc_checker (
    input logic       clk,
    input logic       aclr_term,
    input logic       spre_term,
    input logic       or_sum,
    input logic       oe_term,
    input logic [1:0] cfg,
    input logic       pad_in,
    input logic       pad_out,
    input logic       pad_oe,
    input logic       fb_true,
    input logic       fb_comp,
    input logic       reg_q
);
    p_load_r2: assert property (@(posedge clk) disable iff (aclr_term)
        !spre_term |=> reg_q == $past(or_sum));

    p_preset_r3: assert property (@(posedge clk) disable iff (aclr_term)
        spre_term |=> reg_q);

    p_clear_r4: assert property (@(negedge clk) disable iff (!aclr_term)
        aclr_term |-> !reg_q);

    p_reg_pol_r5: assert property (@(negedge clk) disable iff (aclr_term)
        !cfg[0] |-> pad_out == (cfg[1] ? reg_q : !reg_q));

    p_comb_r6: assert property (@(negedge clk) disable iff (aclr_term)
        cfg[0] |-> pad_out == (cfg[1] ? or_sum : !or_sum));

    p_oe_r7: assert property (@(negedge clk) disable iff (aclr_term)
        pad_oe == oe_term);

    p_fb_r8: assert property (@(negedge clk) disable iff (aclr_term)
        (!cfg[0] |-> fb_true == reg_q) and (fb_comp != fb_true));

    p_fb_pin_r9: assert property (@(negedge clk) disable iff (aclr_term)
        cfg[0] |-> fb_true == pad_in);
endmodule

bind pld_macrocell pld_mc_checker u_chk (
    .clk       (clk),
    .aclr_term (aclr_term),
    .spre_term (spre_term),
    .or_sum    (or_sum),
    .oe_term   (oe_term),
    .cfg       (cfg),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .fb_true   (fb_true),
    .fb_comp   (fb_comp),
    .reg_q     (reg_q)
);

// File: tb/pld_macrocell_test.sv
`timescale 1ns/1ps
module pld_macrocell_test;
    logic       clk = 1'b0;
    logic       aclr_term = 1'b1;
    logic       spre_term = 1'b0;
    logic       or_sum = 1'b0;
    logic       oe_term = 1'b0;
    logic [1:0] cfg = 2'b00;
    logic       pad_in = 1'b0;
    logic       pad_out, pad_oe, fb_true, fb_comp;

    int n_run = 0;
    int n_fail = 0;
    logic mq = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pld_macrocell uut (
        .clk(clk), .aclr_term(aclr_term), .spre_term(spre_term),
        .or_sum(or_sum), .oe_term(oe_term), .cfg(cfg), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .fb_true(fb_true), .fb_comp(fb_comp)
    );

    function automatic logic exp_out(input logic [1:0] c, input logic q, input logic s);
        logic r;
        r = c[0] ? s : q;
        return c[1] ? r : ~r;
    endfunction

    function automatic logic exp_fb(input logic [1:0] c, input logic q, input logic p);
        return c[0] ? p : q;
    endfunction

    task automatic chk(input string tag, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all(input string tag);
        chk({tag, " R5/R6 pad_out"}, pad_out, exp_out(cfg, mq, or_sum));
        chk({tag, " R7 pad_oe"}, pad_oe, oe_term);
        chk({tag, " R8/R9 fb_true"}, fb_true, exp_fb(cfg, mq, pad_in));
        chk({tag, " R8 fb_comp"}, fb_comp, ~exp_fb(cfg, mq, pad_in));
    endtask

    // one cycle: drive after falling edge, check, then model the rising edge
    task automatic step(input string tag, input logic a, input logic p, input logic s,
                        input logic o, input logic [1:0] c, input logic pin);
        @(negedge clk);
        aclr_term = a; spre_term = p; or_sum = s; oe_term = o; cfg = c; pad_in = pin;
        if (a) mq = 1'b0;
        #1;
        check_all(tag);
        @(posedge clk);
        if (!a) mq = p ? 1'b1 : s;
    endtask

    initial begin
        #100000;
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        // reset state under clear (R4), registered active-high (R1)
        step("reset R4", 1'b1, 1'b0, 1'b1, 1'b1, 2'b10, 1'b1);
        chk("reset R4 reg low", fb_true, 1'b0);
        // R2 load
        step("load R2", 1'b0, 1'b0, 1'b1, 1'b1, 2'b10, 1'b0);
        step("load R2 seen", 1'b0, 1'b0, 1'b0, 1'b1, 2'b10, 1'b0);
        chk("R2 loaded 1", fb_true, 1'b1);
        // R3 preset overrides data 0
        step("preset R3", 1'b0, 1'b1, 1'b0, 1'b0, 2'b10, 1'b0);
        step("preset R3 seen", 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0);
        chk("R3 preset gives 1", fb_true, 1'b1);
        chk("R5 active-low reg", pad_out, 1'b0);
        // R4 clear mid-cycle, without clock edge
        @(negedge clk);
        #0.5;
        aclr_term = 1'b1;
        #0.5;
        chk("R4 async clear no edge", fb_true, 1'b0);
        mq = 1'b0;
        // R4 clear beats preset
        step("clr>pre R4", 1'b1, 1'b1, 1'b1, 1'b0, 2'b10, 1'b0);
        step("clr>pre R4 after", 1'b1, 1'b1, 1'b1, 1'b0, 2'b10, 1'b0);
        chk("R4 clear wins over preset", fb_true, 1'b0);
        step("release", 1'b0, 1'b0, 1'b0, 1'b0, 2'b10, 1'b0);
        // R6/R9 combinational, disabled pin used as input
        step("comb hi R6", 1'b0, 1'b0, 1'b1, 1'b0, 2'b11, 1'b0);
        chk("R9 fb from pad", fb_true, 1'b0);
        step("comb lo R6", 1'b0, 1'b0, 1'b1, 1'b0, 2'b01, 1'b1);
        chk("R6 active-low comb", pad_out, 1'b0);
        chk("R9 fb from pad 1", fb_true, 1'b1);
        // random mix over all four modes (R1)
        for (int i = 0; i < 2000; i++) begin
            logic [31:0] r;
            r = $urandom;
            step("random R1", (r[3:0] == 4'd0), (r[6:4] == 3'd0), r[7], r[8],
                 r[10:9], r[11]);
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule